// File: doc/BRIEF.md
# Bit-Serial Configurable Logic Cell

This block is a fine-grained programmable cell for bit-serial arithmetic. Four 16-entry lookup tables each read a four-bit address. The low three address bits come from one of two input banks. The top bit comes either from that bank or from a programmable feedback source. Two pairing multiplexers, steered by data inputs, merge a table pair into a five-input function. Each of the four main outputs is taken either directly or through its own flip-flop. Two further flip-flops delay two side inputs by one cycle, which gives a shift stage for serial operands.

The cell is programmed through an 84-bit shift chain. The chain loads one bit per clock while `cfg_en` is high, and during loading every flip-flop keeps its value. A loaded cell can implement a bit-serial full adder. The sum leaves through a bypassed output and the carry returns through a flip-flop, so operands stream in least significant bit first.

Top module: `bitser_cell`

## Requirements
- R1: An active-high `rst` clears all six flip-flops to 0 at the next clock edge, so every registered output and both `e` bits then read 0. The configuration chain keeps its contents across reset.
- R2: Chain bits [16i+15:16i] hold table i. The table is addressed as {s3,s2,s1,s0}, where s0 is the least significant bit and s = a[3:0] when bank bit 64+i is 0.
- R3: When bank bit 64+i is 1, table i takes s = b[3:0] in place of a[3:0].
- R4: The main multiplexer outputs are: out0 = a[4] ? T1 : T0; out1 = T1; out2 = b[4] ? T3 : T2; out3 = T3.
- R5: Chain bit 80+i set to 1 makes d[i] the flip-flop that samples out i on each clock edge outside configuration. Set to 0, d[i] is out i combinationally.
- R6: The 3-bit feedback code at chain bits [68+3i+2:68+3i] selects table i's top address bit: 000 = s3, 010 = constant 1, 001 and 011 = constant 0.
- R7: Feedback code 1jj feeds flip-flop j's state into table i's top address bit, whatever d[j]'s bypass setting is. No combinational loop can form.
- R8: Outside configuration, e[k] equals c[k] from the previous clock edge.
- R9: While `cfg_en` is high, each clock shifts the chain one place toward bit 0 with `cfg_in` entering bit 83. The first bit sent ends in bit 0 after 84 clocks. All six flip-flops hold their values.
- R10: A cell configured as a serial full adder, with the carry held in flip-flop 1 and fed back, outputs the correct sum bit of two streamed 16-bit operands on each cycle. Once all bits are in, the carry-out appears on d[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high flip-flop reset |
| cfg_en | input | 1 | Configure mode: shift chain, freeze flip-flops |
| cfg_in | input | 1 | Serial configuration data |
| a | input | 5 | Bank A address bits [3:0], pair-0 steer [4] |
| b | input | 5 | Bank B address bits [3:0], pair-1 steer [4] |
| c | input | 2 | Shift-stage inputs |
| d | output | 4 | Main outputs |
| e | output | 2 | Shift-stage outputs |

## Verification
Within a single cycle, table i's lookup depends on flip-flop state that was captured in the previous cycle, and that same flip-flop is updated at the clock edge. A wrong feedback path or a wrong update order therefore corrupts the very next bit. The serial adder exposes this. Each sum bit is judged before the edge, combining the present operand bits with the carry registered one cycle earlier, and the final carry is read after the last edge. A second overlap is reconfiguration during live operation. Reloading an identical configuration while the side inputs toggle must leave `e` and the registered `d` values exactly as they were.

// File: rtl/bitser_cell.sv
module bitser_cell #(
  parameter int NT = 4,
  parameter int TB = 16,
  parameter int FW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_en,
  input  logic       cfg_in,
  input  logic [4:0] a,
  input  logic [4:0] b,
  input  logic [1:0] c,
  output logic [3:0] d,
  output logic [1:0] e
);
  localparam int BK = NT * TB;
  localparam int FB = BK + NT;
  localparam int RG = FB + NT * FW;
  localparam int CW = RG + NT;

  logic [CW-1:0] cfg;
  logic [NT-1:0] q, t, m, rsel;
  logic [1:0]    sr;

  always_ff @(posedge clk)
    if (cfg_en) cfg <= {cfg_in, cfg[CW-1:1]};

  always_ff @(posedge clk)
    if (rst) begin
      q  <= '0;
      sr <= '0;
    end else if (!cfg_en) begin
      q  <= m;
      sr <= c;
    end

  for (genvar i = 0; i < NT; i++) begin : g_tab
    logic [3:0]    src;
    logic [FW-1:0] fs;
    logic          top;
    logic [TB-1:0] lut;
    assign src = cfg[BK+i] ? b[3:0] : a[3:0];
    assign fs  = cfg[FB+FW*i +: FW];
    assign lut = cfg[TB*i +: TB];
    always_comb
      if (fs[2])              top = q[fs[1:0]];
      else if (fs == 3'b000)  top = src[3];
      else                    top = (fs == 3'b010);
    assign t[i] = lut[{top, src[2:0]}];
  end

  assign m    = {t[3], b[4] ? t[3] : t[2], t[1], a[4] ? t[1] : t[0]};
  assign rsel = cfg[RG +: NT];
  assign d    = (rsel & q) | (~rsel & m);
  assign e    = sr;

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (q == '0 && e == 2'b00));
  // R9
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> ($stable(q) && $stable(e)));
  // R9
  cfg_shift_chk: assert property (@(posedge clk) cfg_en |=> cfg[CW-1] == $past(cfg_in));
  // R8
  shift_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> e == $past(c));
  // R5
  reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> q == $past(m));
endmodule

// File: tb/sim_bitser_cell.sv
module sim_bitser_cell;
  logic clk = 0, rst = 0, cfg_en = 0, cfg_in = 0;
  logic [4:0] a = 0, b = 0;
  logic [1:0] c = 0;
  logic [3:0] d;
  logic [1:0] e;
  int total = 0, bad = 0;
  logic [83:0] cv;
  logic [3:0] qm = 0;
  logic [1:0] em = 0;

  bitser_cell u0 (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
                  .a(a), .b(b), .c(c), .d(d), .e(e));

  always #5 clk = ~clk;

  function automatic logic [83:0] mk(input logic [63:0] tabs, input logic [3:0] bank,
                                     input logic [11:0] fbs, input logic [3:0] regs);
    return {regs, fbs, bank, tabs};
  endfunction

  function automatic logic [3:0] model_m(input logic [83:0] v, input logic [4:0] ai,
                                         input logic [4:0] bi, input logic [3:0] qq);
    logic [3:0] tt;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] s;
      logic [2:0] f;
      logic x;
      s = v[64+i] ? bi[3:0] : ai[3:0];
      f = v[68+3*i +: 3];
      if (f[2]) x = qq[f[1:0]];
      else if (f == 3'd0) x = s[3];
      else x = (f == 3'd2);
      tt[i] = v[16*i + {x, s[2:0]}];
    end
    return {tt[3], bi[4] ? tt[3] : tt[2], tt[1], ai[4] ? tt[1] : tt[0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [4:0] ai, input logic [4:0] bi, input logic [1:0] ci,
                      input string tag);
    logic [3:0] mm;
    a = ai; b = bi; c = ci;
    @(negedge clk);
    mm = model_m(cv, ai, bi, qm);
    chk(tag, {2'b0, e, d}, {2'b0, em, (cv[83:80] & qm) | (~cv[83:80] & mm)});
    @(posedge clk);
    qm = mm; em = ci;
    #1;
  endtask

  task automatic load(input logic [83:0] v);
    cfg_en = 1;
    for (int i = 0; i < 84; i++) begin
      cfg_in = v[i];
      @(posedge clk); #1;
    end
    cfg_en = 0;
    cv = v;
  endtask

  task automatic do_rst;
    rst = 1;
    @(posedge clk); #1;
    rst = 0; qm = 0; em = 0;
  endtask

  initial begin
    #1_500_000;
    chk("watchdog", 8'd1, 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] tabs;
    logic [3:0] dsave;
    void'($urandom(32'd2024));
    @(posedge clk); #1;

    // R1: reset clears registered outputs, configuration survives reset
    load(mk({64{1'b1}}, 4'h0, {4{3'd0}}, 4'hF));
    c = 2'b11; a = 5'h1F;
    do_rst;
    @(negedge clk);
    chk("R1 reset state", {2'b0, e, d}, 8'h00);
    @(posedge clk); #1; qm = 4'hF; em = 2'b11;
    step(5'h00, 5'h00, 2'b00, "R1 config kept");

    // R2: bank A addressing, LSB = a[0]
    tabs = {$urandom, $urandom};
    load(mk(tabs, 4'h0, {4{3'd0}}, 4'h0));
    for (int k = 0; k < 16; k++) begin
      a = 5'(k); b = 0;
      @(negedge clk);
      chk("R2 table0 via a", {7'b0, d[0]}, {7'b0, tabs[k]});
      step(5'(k), 5'h0, 2'b00, "R2 model");
    end

    // R3: bank B for table 1
    load(mk(tabs, 4'b0010, {4{3'd0}}, 4'h0));
    for (int k = 0; k < 16; k++) begin
      a = 5'($urandom); b = 5'(k);
      @(negedge clk);
      chk("R3 table1 via b", {7'b0, d[1]}, {7'b0, tabs[16+k]});
    end

    // R4: pairing multiplexers
    for (int k = 0; k < 16; k++) begin
      a = 5'(16 + k); b = 5'(16 + k);
      @(negedge clk);
      chk("R4 a4 picks T1", {7'b0, d[0]}, {7'b0, tabs[16+k]});
    end
    load(mk(tabs, 4'h0, {4{3'd0}}, 4'h0));
    for (int k = 0; k < 16; k++) begin
      a = 5'(k); b = 5'(16 + k);
      @(negedge clk);
      chk("R4 b4 picks T3", {6'b0, d[3:2]}, {6'b0, tabs[48+k], tabs[48+k]});
    end

    // R5: registered output lags by one edge
    load(mk({48'h0, 16'hFFFF}, 4'h0, {4{3'd0}}, 4'b0001));
    do_rst;
    a = 5'h03;
    @(negedge clk);
    chk("R5 before edge", {7'b0, d[0]}, 8'h00);
    @(posedge clk); #1; qm = model_m(cv, 5'h03, 5'h0, 4'h0); em = 0;
    @(negedge clk);
    chk("R5 after edge", {7'b0, d[0]}, 8'h01);
    @(posedge clk); #1;

    // R6: constant feedback codes on table 0
    load(mk(tabs, 4'h0, {9'd0, 3'd2}, 4'h0));
    for (int k = 0; k < 16; k++) begin
      a = 5'(k);
      @(negedge clk);
      chk("R6 const1", {7'b0, d[0]}, {7'b0, tabs[8 + (k % 8)]});
    end
    load(mk(tabs, 4'h0, {9'd0, 3'd1}, 4'h0));
    for (int k = 0; k < 16; k++) begin
      a = 5'(k);
      @(negedge clk);
      chk("R6 const0", {7'b0, d[0]}, {7'b0, tabs[k % 8]});
    end

    // R8: shift stage delay
    for (int k = 0; k < 8; k++) begin
      logic [1:0] cc;
      cc = 2'($urandom);
      c = cc;
      @(posedge clk); #1;
      chk("R8 shift delay", {6'b0, e}, {6'b0, cc});
    end

    // R7 and R10: serial adder, carry registered in flip-flop 1 and fed back
    begin
      logic [15:0] t0, t1;
      for (int k = 0; k < 16; k++) begin
        t0[k] = k[0] ^ k[1] ^ k[3];
        t1[k] = (k[0] & k[1]) | (k[0] & k[3]) | (k[1] & k[3]);
      end
      load(mk({32'h0, t1, t0}, 4'h0, {3'd1, 3'd1, 3'd5, 3'd5}, 4'b0010));
    end
    for (int p = 0; p < 24; p++) begin
      logic [15:0] x, y;
      logic [16:0] s;
      x = 16'($urandom); y = 16'($urandom);
      if (p == 0) begin x = 16'hFFFF; y = 16'h0001; end
      if (p == 1) begin x = 16'hFFFF; y = 16'hFFFF; end
      if (p == 2) begin x = 16'h0000; y = 16'h0000; end
      s = x + y;
      do_rst;
      for (int k = 0; k < 16; k++) begin
        a = {3'b000, y[k], x[k]};
        @(negedge clk);
        chk("R10 sum bit", {7'b0, d[0]}, {7'b0, s[k]});
        @(posedge clk); #1;
      end
      chk("R7 carry out", {7'b0, d[1]}, {7'b0, s[16]});
    end

    // R9: reload same configuration while live; flip-flops and e frozen
    tabs = {$urandom, $urandom};
    load(mk(tabs, 4'b0101, {3'd4, 3'd6, 3'd0, 3'd7}, 4'hF));
    do_rst;
    for (int k = 0; k < 10; k++) step(5'($urandom), 5'($urandom), 2'($urandom), "R9 prerun");
    dsave = d;
    cfg_en = 1;
    for (int i = 0; i < 84; i++) begin
      cfg_in = cv[i]; c = 2'($urandom); a = 5'($urandom);
      @(posedge clk); #1;
      chk("R9 e frozen", {6'b0, e}, {6'b0, em});
    end
    cfg_en = 0;
    @(negedge clk);
    chk("R9 q frozen", {4'b0, d}, {4'b0, dsave});
    @(posedge clk); #1;

    // Random configurations mixed with random inputs
    for (int r = 0; r < 12; r++) begin
      load({20'($urandom), $urandom, $urandom});
      do_rst;
      for (int k = 0; k < 40; k++)
        step(5'($urandom), 5'($urandom), 2'($urandom), "R5 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule